// File: doc/BRIEF.md
# Automatic Multi-Byte Serial Transfer Engine

This block runs a whole burst of full-duplex byte exchanges over a synchronous three-wire serial link. The CPU does not step in for each byte. A small local buffer RAM holds the bytes to transmit. A count-down pointer picks the slot used for each byte. When receive is enabled, every byte that comes back on the serial input overwrites the slot its transmit byte came from. The burst ends with one interrupt flag.

The host first loads the buffer through a simple write port and sets the pointer to N-1 for an N-byte burst. It then writes any value to the shift register. That write only starts the burst; the value written is replaced before any bit is shifted. For each byte the engine does four things in order:
- copies the slot the pointer selects into the shift register;
- shifts eight bits, MSB first, on a serial clock divided down from the system clock;
- stores the received byte;
- decrements the pointer.

After the byte at pointer 0 has been stored, the engine raises the interrupt flag, drops busy and stops. The pointer is left at 0.

Top module: `burst_sio`

## Requirements
- R1: After reset the pointer reads 0, `irqFlag` and `busy` are low, `sck` is high and `so` is low.
- R2: A write on `trigWe` while idle starts a burst. The `trigData` value is never shifted out: the first byte on `so` is the buffer slot selected by the pointer at the time of the trigger.
- R3: Bytes leave on `so` in the order slot P, P-1, ..., 0, where P is the starting pointer, so P+1 bytes are sent in total. Each byte goes MSB first over 8 `sck` low/high cycles, each phase DIV system clocks long. `so` changes only when `sck` falls, and `sck` rests high whenever the engine is idle.
- R4: `si` is sampled on each rising `sck` edge, MSB first. With `rxEn` high, the received byte is written into the same slot its transmit byte was taken from.
- R5: With `rxEn` low, the buffer RAM is left unchanged by the burst, and the pointer still counts down to 0.
- R6: `irqFlag` rises in the same cycle that `busy` falls, only after the last byte has been stored, with the pointer at 0. No further `sck` activity follows. The flag stays set until an `irqClr` pulse clears it.
- R7: While `busy` is high, buffer writes (`bufWe`), pointer writes (`ptrWe`) and further triggers (`trigWe`) are ignored.
- R8: While a byte is being shifted, the pointer shows that byte's slot. The pointer drops by exactly one after each stored byte.
- R9: A starting pointer of 0 gives a one-byte burst, and a starting pointer of 31 sends all 32 slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bufWe | input | 1 | Buffer write strobe (ignored while busy) |
| bufAddr | input | PTR_W | Buffer write address |
| bufWdata | input | DATA_W | Buffer write data |
| ptrWe | input | 1 | Pointer write strobe (ignored while busy) |
| ptrWdata | input | PTR_W | New pointer value |
| trigWe | input | 1 | Shift-register write; starts a burst when idle |
| trigData | input | DATA_W | Value written with the trigger; never transmitted |
| rxEn | input | 1 | Store received bytes into the buffer when high |
| irqClr | input | 1 | Clears the interrupt flag |
| rdAddr | input | PTR_W | Buffer read address |
| rdData | output | DATA_W | Buffer contents at rdAddr |
| ptr | output | PTR_W | Current transfer pointer |
| busy | output | 1 | High from the trigger until the burst ends |
| irqFlag | output | 1 | Burst-complete interrupt flag |
| sck | output | 1 | Serial clock, idles high |
| so | output | 1 | Serial data out |
| si | input | 1 | Serial data in |

## Verification
The properties assume that host strobes are single-cycle pulses and that `irqClr` is never asserted in the cycle the flag is being set. They also assume `si` settles well before the rising `sck` edge that samples it. The bench drives every host strobe between clock edges for one cycle. It changes `si` only just after a falling `sck` edge, which leaves DIV full cycles before the sample. It also makes deliberate buffer, pointer and trigger writes in the middle of a burst to exercise the ignore rules.

// File: rtl/burst_sio_pkg.sv
package burst_sio_pkg;

  // Strobes issued by the sequencer to the datapath, one cycle each
  typedef struct packed {
    logic loadSh;    // copy selected buffer slot into shift register
    logic fallEdge;  // drive sck low and present next bit on so
    logic riseEdge;  // drive sck high and shift si in
    logic storeRx;   // write shift register back into selected slot
    logic decPtr;    // step the pointer down by one
    logic setIrq;    // burst finished
  } strobe_t;

  typedef enum logic [1:0] {
    S_IDLE,
    S_LOAD,
    S_SHIFT,
    S_STORE
  } state_t;

endpackage

// File: rtl/burst_sio_ctrl.sv
module burst_sio_ctrl
  import burst_sio_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV    = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    ptrZero,
  output strobe_t stb,
  output logic    busy
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DIV - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(DATA_W - 1);

  state_t          state, stateNext;
  logic [CW-1:0]   divCnt;
  logic            highNext;   // 0: next edge is falling, 1: next edge is rising
  logic [BW-1:0]   bitCnt;
  logic            edgeTick;

  assign edgeTick = (state == S_SHIFT) && (divCnt == CNT_LAST);
  assign busy     = (state != S_IDLE);

  always_comb begin
    stb       = '0;
    stateNext = state;
    unique case (state)
      S_IDLE:  if (start) stateNext = S_LOAD;
      S_LOAD: begin
        stb.loadSh = 1'b1;
        stateNext  = S_SHIFT;
      end
      S_SHIFT: begin
        if (edgeTick) begin
          stb.fallEdge = !highNext;
          stb.riseEdge = highNext;
          if (highNext && (bitCnt == BIT_LAST)) stateNext = S_STORE;
        end
      end
      S_STORE: begin
        stb.storeRx = 1'b1;
        if (ptrZero) begin
          stb.setIrq = 1'b1;
          stateNext  = S_IDLE;
        end else begin
          stb.decPtr = 1'b1;
          stateNext  = S_LOAD;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      divCnt   <= '0;
      highNext <= 1'b0;
      bitCnt   <= '0;
    end else begin
      state <= stateNext;
      if (state == S_LOAD) begin
        divCnt   <= '0;
        highNext <= 1'b0;
        bitCnt   <= '0;
      end else if (state == S_SHIFT) begin
        if (edgeTick) begin
          divCnt   <= '0;
          highNext <= !highNext;
          if (highNext) bitCnt <= bitCnt + 1'b1;
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/burst_sio_dp.sv
module burst_sio_dp
  import burst_sio_pkg::*;
#(
  parameter int PTR_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              busy,
  input  logic              bufWe,
  input  logic [PTR_W-1:0]  bufAddr,
  input  logic [DATA_W-1:0] bufWdata,
  input  logic              ptrWe,
  input  logic [PTR_W-1:0]  ptrWdata,
  input  logic              trigWe,
  input  logic [DATA_W-1:0] trigData,
  input  logic              rxEn,
  input  logic              irqClr,
  input  logic              si,
  input  logic [PTR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [PTR_W-1:0]  ptr,
  output logic              ptrZero,
  output logic              irqFlag,
  output logic              sck,
  output logic              so
);

  localparam int DEPTH = 1 << PTR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] shReg;

  // Buffer RAM: the engine's write-back has priority, host writes only when idle
  always_ff @(posedge clk) begin
    if (stb.storeRx && rxEn)
      mem[ptr] <= shReg;
    else if (bufWe && !busy)
      mem[bufAddr] <= bufWdata;
  end

  assign rdData  = mem[rdAddr];
  assign ptrZero = (ptr == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      ptr     <= '0;
      irqFlag <= 1'b0;
      sck     <= 1'b1;
      so      <= 1'b0;
    end else begin
      // Shift register: the trigger value lands here but is replaced before shifting
      if (stb.loadSh)
        shReg <= mem[ptr];
      else if (stb.riseEdge)
        shReg <= {shReg[DATA_W-2:0], si};
      else if (trigWe && !busy)
        shReg <= trigData;

      if (stb.fallEdge) begin
        sck <= 1'b0;
        so  <= shReg[DATA_W-1];
      end else if (stb.riseEdge) begin
        sck <= 1'b1;
      end

      if (stb.decPtr)
        ptr <= ptr - 1'b1;
      else if (ptrWe && !busy)
        ptr <= ptrWdata;

      if (stb.setIrq)
        irqFlag <= 1'b1;
      else if (irqClr)
        irqFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/burst_sio.sv
module burst_sio
  import burst_sio_pkg::*;
#(
  parameter int PTR_W  = 5,
  parameter int DATA_W = 8,
  parameter int DIV    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bufWe,
  input  logic [PTR_W-1:0]  bufAddr,
  input  logic [DATA_W-1:0] bufWdata,
  input  logic              ptrWe,
  input  logic [PTR_W-1:0]  ptrWdata,
  input  logic              trigWe,
  input  logic [DATA_W-1:0] trigData,
  input  logic              rxEn,
  input  logic              irqClr,
  input  logic [PTR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [PTR_W-1:0]  ptr,
  output logic              busy,
  output logic              irqFlag,
  output logic              sck,
  output logic              so,
  input  logic              si
);

  strobe_t stb;
  logic    ptrZero;

  burst_sio_ctrl #(.DATA_W(DATA_W), .DIV(DIV)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (trigWe),
    .ptrZero (ptrZero),
    .stb     (stb),
    .busy    (busy)
  );

  burst_sio_dp #(.PTR_W(PTR_W), .DATA_W(DATA_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .busy     (busy),
    .bufWe    (bufWe),
    .bufAddr  (bufAddr),
    .bufWdata (bufWdata),
    .ptrWe    (ptrWe),
    .ptrWdata (ptrWdata),
    .trigWe   (trigWe),
    .trigData (trigData),
    .rxEn     (rxEn),
    .irqClr   (irqClr),
    .si       (si),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .ptr      (ptr),
    .ptrZero  (ptrZero),
    .irqFlag  (irqFlag),
    .sck      (sck),
    .so       (so)
  );

endmodule

// File: rtl/burst_sio_chk.sv
module burst_sio_chk #(
  parameter int PTR_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             ptrWe,
  input logic             irqClr,
  input logic [PTR_W-1:0] ptr,
  input logic             busy,
  input logic             irqFlag,
  input logic             sck,
  input logic             so
);

  AST_SCK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> sck);                                                        // R3

  AST_SO_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(so) |-> $fell(sck));                                          // R3

  AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> (!busy && $past(busy) && (ptr == '0)));             // R6

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !irqClr) |=> irqFlag);                                     // R6

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busy) && busy && !$stable(ptr)) |-> (ptr == $past(ptr) - 1'b1)); // R8

  AST_BUSY_PTR_IGNORE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && ptrWe) |=> ((ptr == $past(ptr)) || (ptr == $past(ptr) - 1'b1))); // R7

endmodule

bind burst_sio burst_sio_chk #(.PTR_W(PTR_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .ptrWe   (ptrWe),
  .irqClr  (irqClr),
  .ptr     (ptr),
  .busy    (busy),
  .irqFlag (irqFlag),
  .sck     (sck),
  .so      (so)
);

// File: tb/burst_sio_test.sv
module burst_sio_test;
  localparam int PTR_W  = 5;
  localparam int DATA_W = 8;
  localparam int DIV    = 2;
  localparam int DEPTH  = 1 << PTR_W;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rstN;
  logic              bufWe, ptrWe, trigWe, rxEn, irqClr, si;
  logic [PTR_W-1:0]  bufAddr, ptrWdata, rdAddr;
  logic [DATA_W-1:0] bufWdata, trigData, rdData;
  logic [PTR_W-1:0]  ptr;
  logic              busy, irqFlag, sck, so;

  burst_sio #(.PTR_W(PTR_W), .DATA_W(DATA_W), .DIV(DIV)) uut (.*);

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [DATA_W-1:0] model [DEPTH];
  logic [DATA_W-1:0] txQ [$];
  logic [DATA_W-1:0] rxQ [$];
  int                ptrQ [$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor and serial slave: drives si after each falling sck, captures so on rising sck
  initial begin : monitor
    int                bitIdx;
    logic [DATA_W-1:0] cap;
    logic [DATA_W-1:0] curRx;
    int                e;
    bitIdx = 0;
    cap    = '0;
    curRx  = '0;
    si     = 1'b0;
    wait (rstN === 1'b1);
    @(posedge clk);
    forever begin
      @(sck);
      if (sck === 1'b0) begin
        if (bitIdx == 0) begin
          curRx = (rxQ.size() != 0) ? rxQ.pop_front() : '0;
          if (ptrQ.size() != 0) begin
            e = ptrQ.pop_front();
            check(ptr == PTR_W'(e), "R8 pointer during byte", ptr, e);
          end
        end
        #1 si = curRx[DATA_W-1-bitIdx];
      end else begin
        cap = {cap[DATA_W-2:0], so};
        bitIdx++;
        if (bitIdx == DATA_W) begin
          bitIdx = 0;
          if (txQ.size() == 0) begin
            check(1'b0, "R7 unexpected extra byte", cap, 0);
          end else begin
            e = txQ.pop_front();
            check(cap == DATA_W'(e), "R2 R3 byte on so", cap, e);
          end
        end
      end
    end
  end

  task automatic wrBuf(input int a, input logic [DATA_W-1:0] d);
    @(negedge clk); bufWe = 1'b1; bufAddr = PTR_W'(a); bufWdata = d;
    @(negedge clk); bufWe = 1'b0;
  endtask

  task automatic wrPtr(input int p);
    @(negedge clk); ptrWe = 1'b1; ptrWdata = PTR_W'(p);
    @(negedge clk); ptrWe = 1'b0;
  endtask

  task automatic trig(input logic [DATA_W-1:0] d);
    @(negedge clk); trigWe = 1'b1; trigData = d;
    @(negedge clk); trigWe = 1'b0;
  endtask

  task automatic checkBuffer(input string tag);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk); rdAddr = PTR_W'(i);
      #1 check(rdData == model[i], tag, rdData, model[i]);
    end
  endtask

  // Driver: pushes expected traffic, starts the burst, waits for completion
  task automatic runBurst(input int startPtr, input bit rx, input logic [DATA_W-1:0] trigVal,
                          input int salt, input bit poke);
    int n;
    rxEn = rx;
    wrPtr(startPtr);
    for (int i = startPtr; i >= 0; i--) begin
      logic [DATA_W-1:0] rb;
      rb = DATA_W'((i * 29) ^ salt ^ 8'h5A);
      txQ.push_back(model[i]);
      rxQ.push_back(rb);
      ptrQ.push_back(i);
      if (rx) model[i] = rb;
    end
    trig(trigVal);
    check(busy == 1'b1, "R2 busy after trigger", busy, 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      wrBuf(DEPTH - 3, 8'hEE);   // R7: must not land
      wrPtr(17);                 // R7: must not land
      trig(8'h00);               // R7: must not restart
    end
    n = 0;
    while (!irqFlag && n < 5000) begin @(negedge clk); n++; end
    check(irqFlag == 1'b1, "R6 irq raised", irqFlag, 1);
    check(busy == 1'b0, "R6 busy low with irq", busy, 0);
    check(ptr == '0, "R6 pointer holds 0", ptr, 0);
    check(txQ.size() == 0, "R3 byte count", txQ.size(), 0);
    repeat (4 * DIV + 4) @(negedge clk);
    check(sck == 1'b1, "R6 sck quiet after burst", sck, 1);
    check(irqFlag == 1'b1, "R6 irq held", irqFlag, 1);
    check(txQ.size() == 0, "R6 no extra byte", txQ.size(), 0);
    @(negedge clk); irqClr = 1'b1;
    @(negedge clk); irqClr = 1'b0;
    check(irqFlag == 1'b0, "R6 irq cleared", irqFlag, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    rstN = 1'b0; bufWe = 0; ptrWe = 0; trigWe = 0; rxEn = 0; irqClr = 0;
    bufAddr = '0; ptrWdata = '0; rdAddr = '0; bufWdata = '0; trigData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(ptr == '0, "R1 reset pointer", ptr, 0);
    check(irqFlag == 1'b0, "R1 reset irq", irqFlag, 0);
    check(busy == 1'b0, "R1 reset busy", busy, 0);
    check(sck == 1'b1, "R1 reset sck", sck, 1);
    check(so == 1'b0, "R1 reset so", so, 0);

    for (int i = 0; i < DEPTH; i++) begin
      model[i] = DATA_W'(i * 7 + 8'h11);
      wrBuf(i, model[i]);
    end
    checkBuffer("R7 idle buffer load");

    // Six-byte burst with receive, plus writes attempted mid-burst
    runBurst(5, 1'b1, 8'hA5, 8'h00, 1'b1);
    checkBuffer("R4 R7 buffer after receive burst");

    // Receive disabled: buffer must stay put
    runBurst(2, 1'b0, 8'hFF, 8'h33, 1'b0);
    checkBuffer("R5 buffer after no-receive burst");

    // Single-byte burst
    runBurst(0, 1'b1, 8'h80, 8'h71, 1'b0);
    checkBuffer("R9 buffer after one-byte burst");

    // Full 32-slot burst
    runBurst(DEPTH - 1, 1'b1, 8'h01, 8'hC4, 1'b0);
    checkBuffer("R9 buffer after full burst");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule